// File: doc/BRIEF.md
# Masked Associative Lookup Table

This block is a small content-addressable store. It holds a set of wide data words, each tagged with a two-bit validity code. A comparand word is matched against every taking-part entry at once. Two mask registers, enabled through a control register, select which bit positions are ignored by the search and which bit positions are protected during writes. The bits that the search ignores act as a per-entry associated field. After a hit, that field of the winning entry can be read back at once, so one word can be split into a key and a payload at any bit boundary.

Software talks to the block over a narrow cycle interface with three active-low strobes. A command write selects the register or entry that later data writes go to, changes an entry's validity, or starts a search. A data write loads the selected register or entry. A command read returns a status word, and a data read returns the associated field of the latched hit. Writing the control, comparand or either mask register starts a search on its own. A small two-state controller latches the search result one cycle later.

Top module: `cam_assoc`

## Requirements
- R1: After reset every entry is Empty, the latched status is clear, `match_n` and `multi_n` are high, and both read types return zero.
- R2: Each entry has a validity code with bit 1 = skip and bit 0 = empty: 00 Valid, 01 Empty, 10 Skip, 11 Random-access. Only Valid entries can hit. Command opcode 7 sets the entry named in command bits [8+:addr] to the code in command bits [17:16].
- R3: A bus cycle happens on any clock with `en_n` low. `wr_n`/`cmd_n` select the cycle type: 0/0 command write, 0/1 data write, 1/0 command read (status), 1/1 data read (associated field). `bus_out` is zero outside read cycles. The command opcode sits in bits [3:0]. Opcodes: 0 none, 1 control, 2 comparand, 3 mask 1, 4 mask 2, 5 entry at address, 6 next free entry, 7 set validity, 8 search.
- R4: A data write to the control, comparand or a mask register, or a command write with opcode 8, starts a search. Its result enters the latched status at the second rising edge after the triggering cycle. Otherwise the latched result holds.
- R5: Status bit 0 is the hit flag and bits [8+:addr] hold the lowest-numbered hitting entry. `match_n` is the inverse of the hit flag.
- R6: Status bit 1 flags that more than one entry hit. `multi_n` is its inverse.
- R7: Control bit 0 applies mask 1 and control bit 2 applies mask 2 to searches. Mask bits set to 1 are ignored in the comparison.
- R8: A data read returns the latched hit entry ANDed with the active search mask. It returns zero when the latched hit flag is clear.
- R9: Control bit 1 applies mask 1 and control bit 3 applies mask 2 to entry writes. Masked bits keep their old value. Any data write to an entry makes that entry Valid.
- R10: With opcode 6 selected, each data write goes to the lowest-numbered Empty entry.
- R11: Status bit 2 is set whenever no entry is Empty.
- R12: A next-free data write while the table is full changes no entry and sets status bit 3. The next command write clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low cycle enable |
| wr_n | input | 1 | Low for writes, high for reads |
| cmd_n | input | 1 | Low for command cycles, high for data cycles |
| bus_in | input | DATA_W | Write data or command word |
| bus_out | output | DATA_W | Read data, zero outside read cycles |
| match_n | output | 1 | Active-low latched hit flag |
| multi_n | output | 1 | Active-low latched multiple-hit flag |

## Verification
The bench uses the default 64-bit words and 16 entries. With 16 entries it can fill the whole table through the next-free path, hit the full and overflow error conditions, and then free one slot again within a few dozen cycles. The 64-bit width lets the two masks split each word into 32-bit key and payload halves, so search masking, protected writes and associated-field readback are all exercised on one entry.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        VC_VALID = 2'b00,
        VC_EMPTY = 2'b01,
        VC_SKIP  = 2'b10,
        VC_RAM   = 2'b11
    } vcode_e;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_TGT_CTRL = 4'd1,
        OP_TGT_CMP  = 4'd2,
        OP_TGT_MSK1 = 4'd3,
        OP_TGT_MSK2 = 4'd4,
        OP_TGT_ADDR = 4'd5,
        OP_TGT_FREE = 4'd6,
        OP_SET_VAL  = 4'd7,
        OP_SEARCH   = 4'd8
    } op_e;

    typedef enum logic [2:0] {
        TG_CTRL,
        TG_CMP,
        TG_MSK1,
        TG_MSK2,
        TG_ADDR,
        TG_FREE
    } tgt_e;

    typedef enum logic {
        ST_IDLE,
        ST_SEARCH
    } fsm_e;

    localparam int SW_HIT      = 0;
    localparam int SW_MULTI    = 1;
    localparam int SW_FULL     = 2;
    localparam int SW_ERR      = 3;
    localparam int SW_ADDR_LSB = 8;
    localparam int CMD_ADDR_LSB = 8;
    localparam int CMD_CODE_LSB = 16;

endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [AW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
        found = |req;
    end
endmodule

// File: rtl/cam_entry_array.sv
module cam_entry_array
    import cam_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_keep,
    input  logic              vc_en,
    input  logic [AW-1:0]     vc_idx,
    input  vcode_e            vc_code,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic [DATA_W-1:0] cmp_mask,
    input  logic [AW-1:0]     rd_idx,
    output logic [DEPTH-1:0]  hit_vec,
    output logic [DEPTH-1:0]  empty_vec,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] word_bus [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DATA_W-1:0] word_q;
        vcode_e            code_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
                code_q <= VC_EMPTY;
            end else if (wr_en && wr_idx == AW'(g)) begin
                word_q <= (word_q & wr_keep) | (wr_data & ~wr_keep);
                code_q <= VC_VALID;
            end else if (vc_en && vc_idx == AW'(g)) begin
                code_q <= vc_code;
            end
        end

        assign word_bus[g]  = word_q;
        assign hit_vec[g]   = (code_q == VC_VALID) &&
                              (((word_q ^ cmp_data) & ~cmp_mask) == '0);
        assign empty_vec[g] = (code_q == VC_EMPTY);
    end

    assign rd_word = word_bus[rd_idx];
endmodule

// File: rtl/cam_assoc.sv
module cam_assoc
    import cam_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              wr_n,
    input  logic              cmd_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              match_n,
    output logic              multi_n
);
    localparam int AW = $clog2(DEPTH);

    // bus cycle decode
    logic cyc_cw, cyc_dw, cyc_cr, cyc_dr;
    assign cyc_cw = !en_n && !wr_n && !cmd_n;
    assign cyc_dw = !en_n && !wr_n &&  cmd_n;
    assign cyc_cr = !en_n &&  wr_n && !cmd_n;
    assign cyc_dr = !en_n &&  wr_n &&  cmd_n;

    op_e           op;
    logic [AW-1:0] cmd_addr;
    vcode_e        cmd_code;
    assign op       = op_e'(bus_in[3:0]);
    assign cmd_addr = bus_in[CMD_ADDR_LSB +: AW];
    assign cmd_code = vcode_e'(bus_in[CMD_CODE_LSB +: 2]);

    // registers
    logic [3:0]        ctl_q;
    logic [DATA_W-1:0] cmp_q, msk1_q, msk2_q;
    tgt_e              tgt_q;
    logic [AW-1:0]     tgt_addr_q;
    logic              err_q;
    logic              st_match_q, st_multi_q;
    logic [AW-1:0]     st_addr_q;
    fsm_e              state_q, state_d;

    logic [DATA_W-1:0] cmp_mask, wr_keep, rd_word;
    logic [DEPTH-1:0]  hit_vec, empty_vec;
    logic              hit_found, hit_many, free_found, full;
    logic [AW-1:0]     hit_idx, free_idx, wr_idx;
    logic              wr_en, vc_en, free_wr_full, compare_req, searching;

    assign cmp_mask = (ctl_q[0] ? msk1_q : '0) | (ctl_q[2] ? msk2_q : '0);
    assign wr_keep  = (ctl_q[1] ? msk1_q : '0) | (ctl_q[3] ? msk2_q : '0);
    assign full     = !free_found;
    assign hit_many = $countones(hit_vec) > 1;

    assign free_wr_full = cyc_dw && (tgt_q == TG_FREE) && full;
    assign wr_en   = cyc_dw && ((tgt_q == TG_ADDR) || (tgt_q == TG_FREE && !full));
    assign wr_idx  = (tgt_q == TG_FREE) ? free_idx : tgt_addr_q;
    assign vc_en   = cyc_cw && (op == OP_SET_VAL);
    assign compare_req = (cyc_dw && (tgt_q inside {TG_CTRL, TG_CMP, TG_MSK1, TG_MSK2}))
                      || (cyc_cw && op == OP_SEARCH);
    assign searching = (state_q == ST_SEARCH);

    cam_entry_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) arr_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(bus_in), .wr_keep(wr_keep),
        .vc_en(vc_en), .vc_idx(cmd_addr), .vc_code(cmd_code),
        .cmp_data(cmp_q), .cmp_mask(cmp_mask), .rd_idx(st_addr_q),
        .hit_vec(hit_vec), .empty_vec(empty_vec), .rd_word(rd_word)
    );

    cam_prio_enc #(.N(DEPTH), .AW(AW)) hit_enc_i (
        .req(hit_vec), .found(hit_found), .idx(hit_idx)
    );

    cam_prio_enc #(.N(DEPTH), .AW(AW)) free_enc_i (
        .req(empty_vec), .found(free_found), .idx(free_idx)
    );

    // register file and command decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            cmp_q      <= '0;
            msk1_q     <= '0;
            msk2_q     <= '0;
            tgt_q      <= TG_CMP;
            tgt_addr_q <= '0;
            err_q      <= 1'b0;
        end else if (cyc_cw) begin
            err_q <= 1'b0;
            unique case (op)
                OP_TGT_CTRL: tgt_q <= TG_CTRL;
                OP_TGT_CMP:  tgt_q <= TG_CMP;
                OP_TGT_MSK1: tgt_q <= TG_MSK1;
                OP_TGT_MSK2: tgt_q <= TG_MSK2;
                OP_TGT_ADDR: begin
                    tgt_q      <= TG_ADDR;
                    tgt_addr_q <= cmd_addr;
                end
                OP_TGT_FREE: tgt_q <= TG_FREE;
                default: ;
            endcase
        end else if (cyc_dw) begin
            unique case (tgt_q)
                TG_CTRL: ctl_q  <= bus_in[3:0];
                TG_CMP:  cmp_q  <= bus_in;
                TG_MSK1: msk1_q <= bus_in;
                TG_MSK2: msk2_q <= bus_in;
                default: ;
            endcase
            if (free_wr_full) err_q <= 1'b1;
        end
    end

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = compare_req ? ST_SEARCH : ST_IDLE;
            ST_SEARCH: state_d = compare_req ? ST_SEARCH : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // result latch, loaded only in ST_SEARCH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_match_q <= 1'b0;
            st_multi_q <= 1'b0;
            st_addr_q  <= '0;
        end else if (state_q == ST_SEARCH) begin
            st_match_q <= hit_found;
            st_multi_q <= hit_many;
            st_addr_q  <= hit_idx;
        end
    end

    // controller: outputs
    always_comb begin
        match_n = !st_match_q;
        multi_n = !st_multi_q;
        bus_out = '0;
        if (cyc_cr) begin
            bus_out[SW_HIT]   = st_match_q;
            bus_out[SW_MULTI] = st_multi_q;
            bus_out[SW_FULL]  = full;
            bus_out[SW_ERR]   = err_q;
            bus_out[SW_ADDR_LSB +: AW] = st_addr_q;
        end else if (cyc_dr && st_match_q) begin
            bus_out = rd_word & cmp_mask;
        end
    end
endmodule

// File: rtl/cam_assoc_chk.sv
module cam_assoc_chk #(
    parameter int DATA_W = 64,
    parameter int AW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_n,
    input logic [DATA_W-1:0] bus_out,
    input logic              match_n,
    input logic              multi_n,
    input logic              searching,
    input logic              st_match,
    input logic              st_multi,
    input logic [AW-1:0]     st_addr,
    input logic              err,
    input logic              full,
    input logic              free_wr_full
);
    a_r6_multi_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        !multi_n |-> !match_n);

    a_r4_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(searching) |-> $stable({st_match, st_multi, st_addr}));

    a_r12_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(free_wr_full));

    a_r12_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        free_wr_full |=> full);

    a_r3_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> bus_out == '0);
endmodule

bind cam_assoc cam_assoc_chk #(.DATA_W(DATA_W), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .bus_out(bus_out),
    .match_n(match_n), .multi_n(multi_n), .searching(searching),
    .st_match(st_match_q), .st_multi(st_multi_q), .st_addr(st_addr_q),
    .err(err_q), .full(full), .free_wr_full(free_wr_full)
);

// File: tb/cam_assoc_tb_top.sv
module cam_assoc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 64;
    localparam int DEPTH  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b1, wr_n = 1'b1, cmd_n = 1'b1;
    logic [DATA_W-1:0] bus_in = '0;
    logic [DATA_W-1:0] bus_out;
    logic match_n, multi_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] exp_q [$];
    logic [1:0]        pin_q [$];
    string             tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_assoc #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .wr_n(wr_n), .cmd_n(cmd_n),
        .bus_in(bus_in), .bus_out(bus_out), .match_n(match_n), .multi_n(multi_n)
    );

    function automatic logic [DATA_W-1:0] stw(bit hit, bit multi, bit full, bit err, int addr);
        logic [DATA_W-1:0] w = '0;
        w[0] = hit; w[1] = multi; w[2] = full; w[3] = err;
        w[8 +: 4] = 4'(addr);
        return w;
    endfunction

    task automatic step();
        @(posedge clk); #1;
        en_n = 1'b1; wr_n = 1'b1; cmd_n = 1'b1; bus_in = '0;
    endtask

    task automatic cmdw(int op, int addr = 0, int code = 0);
        en_n = 1'b0; wr_n = 1'b0; cmd_n = 1'b0;
        bus_in = (64'(code) << 16) | (64'(addr) << 8) | 64'(op);
        step();
    endtask

    task automatic dataw(logic [DATA_W-1:0] v);
        en_n = 1'b0; wr_n = 1'b0; cmd_n = 1'b1; bus_in = v;
        step();
    endtask

    task automatic idle();
        step();
    endtask

    // driver: push expectation, drive a read cycle
    task automatic rd(bit is_data, logic [DATA_W-1:0] exp, bit exp_mn, bit exp_mul, string tag);
        exp_q.push_back(exp);
        pin_q.push_back({exp_mn, exp_mul});
        tag_q.push_back(tag);
        en_n = 1'b0; wr_n = 1'b1; cmd_n = is_data;
        step();
    endtask

    // monitor: pop and compare mid-cycle
    always @(negedge clk) begin
        if (!en_n && wr_n) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: actual %h expected none", bus_out);
            end else begin
                logic [DATA_W-1:0] e;
                logic [1:0] p;
                string t;
                e = exp_q.pop_front();
                p = pin_q.pop_front();
                t = tag_q.pop_front();
                if (bus_out !== e || {match_n, multi_n} !== p) begin
                    n_fail++;
                    $display("FAIL %s: actual bus=%h pins=%b expected bus=%h pins=%b",
                             t, bus_out, {match_n, multi_n}, e, p);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    localparam logic [63:0] A0 = 64'h0000_0000_0000_0001;
    localparam logic [63:0] A1 = 64'hDEAD_BEEF_1234_5678;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd(0, 64'h0, 1, 1, "R1 R3 reset status");
        rd(1, 64'h0, 1, 1, "R1 reset data read");

        // R10 fill three entries via next-free
        cmdw(6);
        dataw(A0); dataw(A1); dataw(A0);

        cmdw(2); dataw(A1); idle();
        rd(0, stw(1, 0, 0, 0, 1), 0, 1, "R4 R5 single hit at 1");
        dataw(A0); idle();
        rd(0, stw(1, 1, 0, 0, 0), 0, 0, "R6 multi hit lowest 0");

        cmdw(7, 0, 2); cmdw(8); idle();
        rd(0, stw(1, 0, 0, 0, 2), 0, 1, "R2 skip entry excluded");
        cmdw(7, 2, 3); cmdw(8); idle();
        rd(0, stw(0, 0, 0, 0, 0), 1, 1, "R2 ram entry excluded");

        // R7 search mask on upper half
        cmdw(3); dataw(64'hFFFF_FFFF_0000_0000);
        cmdw(1); dataw(64'h1);
        cmdw(2); dataw(64'h0000_0000_1234_5678); idle();
        rd(0, stw(1, 0, 0, 0, 1), 0, 1, "R7 masked search hit");
        rd(1, 64'hDEAD_BEEF_0000_0000, 0, 1, "R8 associated field");

        // R9 write mask protects lower half
        cmdw(4); dataw(64'h0000_0000_FFFF_FFFF);
        cmdw(1); dataw(64'h9);
        cmdw(5, 1); dataw(64'h1111_2222_AAAA_BBBB);
        cmdw(8); idle();
        rd(0, stw(1, 0, 0, 0, 1), 0, 1, "R9 masked write kept key");
        rd(1, 64'h1111_2222_0000_0000, 0, 1, "R9 masked write payload");

        // R11 fill to full, R12 overflow
        cmdw(1); dataw(64'h1);
        cmdw(6);
        for (int i = 3; i < DEPTH; i++) dataw(64'(32'h100 + i));
        dataw(64'h0BAD);
        rd(0, stw(1, 0, 1, 1, 1), 0, 1, "R11 R12 full and error");

        cmdw(2); dataw(64'h0BAD); idle();
        rd(0, stw(0, 0, 1, 0, 0), 1, 1, "R12 rejected write absent, error cleared");
        rd(1, 64'h0, 1, 1, "R8 no hit data zero");

        dataw(64'h10F); idle();
        rd(0, stw(1, 0, 1, 0, 15), 0, 1, "R10 last free slot 15");

        cmdw(7, 3, 1); dataw(64'h103); idle();
        rd(0, stw(0, 0, 0, 0, 0), 1, 1, "R2 R11 empty entry excluded, not full");

        cmdw(6); dataw(64'h777);
        cmdw(2); dataw(64'h777); idle();
        rd(0, stw(1, 0, 1, 0, 3), 0, 1, "R10 freed slot reused");

        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule